// File: doc/BRIEF.md
# Dual-Port Semaphore Token Bank

This block holds a small bank of hardware token latches that two independent requesters, called the left and the right port, use to reserve shared resources. A port picks one latch with an index, writes a data word whose bit 0 carries the request (0) or the release (1), and reads back a registered word that tells it whether it currently holds that token. A read returns 0 to the holder and 1 to everyone else. A free latch reads 1 on both sides.

Each latch is a three-state machine. The states are `SEM_FREE`, `SEM_LEFT` (left holds the token) and `SEM_RIGHT` (right holds the token). Its transitions are:

- *acquire*: `SEM_FREE` to `SEM_LEFT` or `SEM_RIGHT`, when one port requests alone, or when both request in the same cycle and the fixed priority picks the winner.
- *handoff*: `SEM_LEFT` to `SEM_RIGHT`, or the reverse, when the holder releases while the other port has a request waiting.
- *release*: holder state to `SEM_FREE`, when the holder releases and nothing is waiting.
- *hold*: any state back to itself otherwise.

Alongside its state, each latch keeps one pending-request bit per port. A request made against a held token is remembered there and wins the token when the holder lets go.

Top module: `sem_bank`

## Requirements
- R1: After reset every latch is in `SEM_FREE` with no pending request, and both read-data outputs are all ones.
- R2: An access is a write when `*_sel` and `*_wr` are both 1. `*_wdata[0]`=0 requests latch `*_idx` and `*_wdata[0]`=1 releases it. Bits 8:1 of the write data have no effect. A request alone on a free latch gives the token to the requesting port in the next cycle.
- R3: An access is a read when `*_sel` and `*_rd` are both 1. One cycle later, `*_rdata` shows the reading port's view of latch `*_idx` in all 9 bits: 0 if that port holds the token, otherwise 1. The value captured is the state before any write made in the same cycle.
- R4: A request (write of 0) from the port that does not hold the token leaves ownership unchanged. A request from the holder also has no effect.
- R5: When the holder writes 1 and the other port has a pending or same-cycle request, the other port holds the token in the next cycle. With no request waiting, the latch becomes free.
- R6: When both ports request a free latch in the same cycle, exactly one wins: the left port if `LEFT_WINS`=1 (the default), otherwise the right port. The loser's request stays pending.
- R7: `*_rdata` changes only on a read by that same port. Writes from either port leave it unchanged.
- R8: A write of 1 by a port that does not hold the token clears that port's own pending request and has no other effect.
- R9: With `*_sel`=0, the write, read, index and data inputs of that port are ignored.
- R10: Each latch is independent: an access to one index never changes another latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left write enable |
| l_rd | input | 1 | Left read enable |
| l_idx | input | 3 | Left latch index |
| l_wdata | input | 9 | Left write data (bit 0 used) |
| l_rdata | output | 9 | Left registered read data |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right write enable |
| r_rd | input | 1 | Right read enable |
| r_idx | input | 3 | Right latch index |
| r_wdata | input | 9 | Right write data (bit 0 used) |
| r_rdata | output | 9 | Right registered read data |

## Verification
A wrong latch state shows at the ports one cycle after the next read of that index: the read data carries the wrong ownership bit. A corrupted pending bit stays hidden until the holder releases. It then appears as a latch that goes free where it should hand off, or the reverse, and is visible on the read that follows. For that reason, the directed cases read both ports immediately after each request, release, handoff and cancel. The random phase mixes many same-index and same-cycle accesses, so that stale pending bits come to the surface.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [1:0] {
        SEM_FREE  = 2'd0,
        SEM_LEFT  = 2'd1,
        SEM_RIGHT = 2'd2
    } sem_state_e;
endpackage

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
#(
    parameter bit LEFT_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_view,
    output logic r_view
);
    sem_state_e state_q, state_d;
    logic       pend_l_q, pend_l_d;
    logic       pend_r_q, pend_r_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEM_FREE;
            pend_l_q <= 1'b0;
            pend_r_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            pend_l_q <= pend_l_d;
            pend_r_q <= pend_r_d;
        end
    end

    // transitions: acquire, handoff, release, hold
    always_comb begin
        state_d  = state_q;
        pend_l_d = pend_l_q;
        pend_r_d = pend_r_q;
        unique case (state_q)
            SEM_FREE: begin
                pend_l_d = 1'b0;
                pend_r_d = 1'b0;
                if (l_req && r_req) begin
                    if (LEFT_WINS) begin
                        state_d  = SEM_LEFT;
                        pend_r_d = 1'b1;
                    end else begin
                        state_d  = SEM_RIGHT;
                        pend_l_d = 1'b1;
                    end
                end else if (l_req) begin
                    state_d = SEM_LEFT;
                end else if (r_req) begin
                    state_d = SEM_RIGHT;
                end
            end
            SEM_LEFT: begin
                pend_l_d = 1'b0;
                pend_r_d = r_req | (pend_r_q & ~r_rel);
                if (l_rel) begin
                    state_d  = pend_r_d ? SEM_RIGHT : SEM_FREE;
                    pend_r_d = 1'b0;
                end
            end
            SEM_RIGHT: begin
                pend_r_d = 1'b0;
                pend_l_d = l_req | (pend_l_q & ~l_rel);
                if (r_rel) begin
                    state_d  = pend_l_d ? SEM_LEFT : SEM_FREE;
                    pend_l_d = 1'b0;
                end
            end
            default: begin
                state_d  = SEM_FREE;
                pend_l_d = 1'b0;
                pend_r_d = 1'b0;
            end
        endcase
    end

    // outputs: inverted ownership view per port
    always_comb begin
        l_view = (state_q != SEM_LEFT);
        r_view = (state_q != SEM_RIGHT);
    end

    a_r2_acquire_left: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_FREE && l_req && !r_req) |=> state_q == SEM_LEFT);
    a_r2_acquire_right: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_FREE && r_req && !l_req) |=> state_q == SEM_RIGHT);
    a_r4_left_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_LEFT && !l_rel) |=> state_q == SEM_LEFT);
    a_r4_right_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_RIGHT && !r_rel) |=> state_q == SEM_RIGHT);
    a_r5_handoff_to_right: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_LEFT && l_rel && (pend_r_q || r_req) && !r_rel) |=> state_q == SEM_RIGHT);
    a_r5_handoff_to_left: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_RIGHT && r_rel && (pend_l_q || l_req) && !l_rel) |=> state_q == SEM_LEFT);
    a_r5_release_free: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_LEFT && l_rel && !pend_r_q && !r_req) |=> state_q == SEM_FREE);
    a_r6_contention: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_FREE && l_req && r_req)
        |=> state_q == (LEFT_WINS ? SEM_LEFT : SEM_RIGHT));
    a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (l_view || r_view));
endmodule

// File: rtl/sem_port.sv
module sem_port #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 9,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr,
    input  logic               rd,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wbit,
    input  logic [NUM_SEM-1:0] views,
    output logic [NUM_SEM-1:0] req_vec,
    output logic [NUM_SEM-1:0] rel_vec,
    output logic [DATA_W-1:0]  rdata
);
    logic wr_hit;
    logic rd_hit;

    always_comb begin
        wr_hit = sel && wr;
        rd_hit = sel && rd;
    end

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
        always_comb begin
            req_vec[g] = wr_hit && (idx == IDX_W'(g)) && !wbit;
            rel_vec[g] = wr_hit && (idx == IDX_W'(g)) &&  wbit;
        end
    end

    // read capture register: pre-write view, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '1;
        end else if (rd_hit) begin
            rdata <= {DATA_W{views[idx]}};
        end
    end

    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_vec, rel_vec}));
    a_r9_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> ($countones({req_vec, rel_vec}) == 0));
    a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(rdata));
    a_r3_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> rdata == {DATA_W{$past(views[idx])}});
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_SEM   = 8,
    parameter int DATA_W    = 9,
    parameter bit LEFT_WINS = 1'b1,
    localparam int IDX_W    = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic [NUM_SEM-1:0] l_req_vec, l_rel_vec, r_req_vec, r_rel_vec;
    logic [NUM_SEM-1:0] l_views, r_views;
    logic               wdata_unused_bits;

    assign wdata_unused_bits = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

    sem_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_lport (
        .clk(clk), .rst_n(rst_n), .sel(l_sel), .wr(l_wr), .rd(l_rd),
        .idx(l_idx), .wbit(l_wdata[0]), .views(l_views),
        .req_vec(l_req_vec), .rel_vec(l_rel_vec), .rdata(l_rdata)
    );

    sem_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rport (
        .clk(clk), .rst_n(rst_n), .sel(r_sel), .wr(r_wr), .rd(r_rd),
        .idx(r_idx), .wbit(r_wdata[0]), .views(r_views),
        .req_vec(r_req_vec), .rel_vec(r_rel_vec), .rdata(r_rdata)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_cell #(.LEFT_WINS(LEFT_WINS)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req_vec[g]), .l_rel(l_rel_vec[g]),
            .r_req(r_req_vec[g]), .r_rel(r_rel_vec[g]),
            .l_view(l_views[g]), .r_view(r_views[g])
        );
    end
endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel = 0, l_wr = 0, l_rd = 0, r_sel = 0, r_wr = 0, r_rd = 0;
    logic [2:0] l_idx = 0, r_idx = 0;
    logic [8:0] l_wdata = 0, r_wdata = 0;
    logic [8:0] l_rdata, r_rdata;

    int checks = 0;
    int errors = 0;
    int own [NS];     // 0 free, 1 left, 2 right
    bit pl  [NS];
    bit pr  [NS];
    logic [8:0] exp_l, exp_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd), .l_idx(l_idx), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd), .r_idx(r_idx), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic check(input logic [8:0] act, input logic [8:0] expv, input string tag, input string side);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s rdata actual %h expected %h", tag, side, act, expv);
        end
    endtask

    // reference update from the requirements
    task automatic model_step(input bit ls, lw, input [2:0] li, input [8:0] lwd,
                              input bit rs, rw, input [2:0] ri, input [8:0] rwd);
        for (int i = 0; i < NS; i++) begin
            bit lq, lx, rq, rx, npr, npl;
            lq = ls && lw && li == i && !lwd[0];
            lx = ls && lw && li == i &&  lwd[0];
            rq = rs && rw && ri == i && !rwd[0];
            rx = rs && rw && ri == i &&  rwd[0];
            case (own[i])
                0: begin
                    if (lq && rq) begin own[i] = 1; pr[i] = 1; end
                    else if (lq) own[i] = 1;
                    else if (rq) own[i] = 2;
                end
                1: begin
                    npr = rq ? 1'b1 : (rx ? 1'b0 : pr[i]);
                    if (lx) begin own[i] = npr ? 2 : 0; pr[i] = 0; end
                    else pr[i] = npr;
                end
                default: begin
                    npl = lq ? 1'b1 : (lx ? 1'b0 : pl[i]);
                    if (rx) begin own[i] = npl ? 1 : 0; pl[i] = 0; end
                    else pl[i] = npl;
                end
            endcase
        end
    endtask

    task automatic cyc(input bit ls, lw, lr, input [2:0] li, input [8:0] lwd,
                       input bit rs, rw, rr, input [2:0] ri, input [8:0] rwd, input string tag);
        l_sel = ls; l_wr = lw; l_rd = lr; l_idx = li; l_wdata = lwd;
        r_sel = rs; r_wr = rw; r_rd = rr; r_idx = ri; r_wdata = rwd;
        @(posedge clk); #1;
        if (ls && lr) exp_l = {9{own[li] != 1}};
        if (rs && rr) exp_r = {9{own[ri] != 2}};
        model_step(ls, lw, li, lwd, rs, rw, ri, rwd);
        @(negedge clk);
        check(l_rdata, exp_l, tag, "left");
        check(r_rdata, exp_r, tag, "right");
    endtask

    task automatic lw_op(input [2:0] i, input [8:0] d, input string tag);
        cyc(1, 1, 0, i, d, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic rw_op(input [2:0] i, input [8:0] d, input string tag);
        cyc(0, 0, 0, 0, 0, 1, 1, 0, i, d, tag);
    endtask
    task automatic rd_both(input [2:0] i, input string tag);
        cyc(1, 0, 1, i, 0, 1, 0, 1, i, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1357);
        for (int i = 0; i < NS; i++) begin own[i] = 0; pl[i] = 0; pr[i] = 0; end
        exp_l = 9'h1FF; exp_r = 9'h1FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(l_rdata, 9'h1FF, "R1", "left");
        check(r_rdata, 9'h1FF, "R1", "right");
        for (int i = 0; i < NS; i++) rd_both(i[2:0], "R1");

        lw_op(3, 9'h1FE, "R2");            // upper bits set, bit0 = 0
        rd_both(3, "R3");                   // left 0, right 1
        rd_both(2, "R10");
        rw_op(3, 9'h000, "R4");             // right requests held token
        lw_op(3, 9'h000, "R4");             // holder re-requests
        rd_both(3, "R4");
        lw_op(3, 9'h001, "R5");             // release -> handoff to right
        rd_both(3, "R5");
        lw_op(3, 9'h000, "R8");             // left pending
        lw_op(3, 9'h001, "R8");             // left cancels
        rd_both(3, "R8");
        rw_op(3, 9'h001, "R8");             // release with nothing waiting
        rd_both(3, "R5");

        cyc(1, 1, 0, 5, 9'h000, 1, 1, 0, 5, 9'h000, "R6");
        rd_both(5, "R6");
        lw_op(5, 9'h001, "R6");             // loser pending gets it
        rd_both(5, "R6");

        cyc(0, 0, 0, 0, 0, 1, 1, 1, 5, 9'h001, "R7");   // right reads and releases
        lw_op(5, 9'h000, "R7");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        rd_both(5, "R7");

        cyc(0, 1, 1, 2, 9'h000, 0, 1, 1, 2, 9'h000, "R9");
        rd_both(2, "R9");
        rd_both(5, "R10");

        for (int n = 0; n < 4000; n++) begin
            cyc($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                3'($urandom_range(0, 3)), 9'($urandom),
                $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                3'($urandom_range(0, 3)), 9'($urandom), "R3");
        end
        for (int i = 0; i < NS; i++) rd_both(i[2:0], "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule